// File: doc/BRIEF.md
# Fractional Microsecond Tick Prescaler

This block turns an oscillator clock into a 1 MHz tick stream, even when the oscillator frequency is not a whole number of megahertz. A 16-bit ratio register gives two fields, each stored as value minus one. Each oscillator cycle counts as (slow field + 1) / (fast field + 1) of a microsecond. An accumulator sums these fractions and produces a single-cycle tick whenever a full microsecond has built up. So 12.8 MHz, 19.2 MHz or 38.4 MHz give an exact average 1 MHz rate, and integer clocks such as 12, 13, 26 or 48 MHz give a strictly periodic one.

The block also keeps a free-running 32-bit microsecond counter that advances on every tick. Both registers sit behind a simple word-wide register port with a write strobe and a combinational read. After reset the ratio register holds a known default, so firmware coming back from a power-down always finds a defined rate before it reprograms the value.

Top module: `usec_prescaler`

## Requirements
- R1: After reset the ratio register reads the parameter RST_CFG (default 0x0000000B), the counter reads 0 and tick_o is low.
- R2: The ratio register is at offset 0x14. Bits [7:0] hold the per-microsecond cycle count minus one (M field), and bits [15:8] hold the microsecond share numerator minus one (S field). Write bits [31:16] are ignored and read back as zero.
- R3: After a ratio write, the number of ticks in the following N clock edges equals floor(N*(S+1)/(M+1)), whenever S <= M.
- R4: When S is 0, tick_o is high for exactly one cycle on every (M+1)-th clock edge after a ratio write, and low on all other edges.
- R5: A ratio write clears the fractional residue. The edge that performs the write produces no tick and does not advance the counter.
- R6: The counter is at offset 0x10. It advances by one on the same edge that raises tick_o, and otherwise holds its value.
- R7: A write to offset 0x10 loads the counter with the written word. The counter wraps from 0xFFFFFFFF to 0 without stopping.
- R8: When S > M, the block treats S as equal to M and produces a tick on every clock edge.
- R9: Reads from any other offset return zero. Writes to any other offset change neither the ratio register nor the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| tick_o | output | 1 | One-cycle pulse per elapsed microsecond |

## Verification
Integer ratios (12, 13, 26 MHz settings) check the exact tick spacing. Fractional ratios (12.8, 19.2, 38.4 MHz settings) check that the residue carries correctly between ticks. Tick counts are compared with a floor-of-product formula over long windows. Random (S, M) pairs cover ratios near 1 and near 1/256, and they also cover the clamped S > M region. A write placed just where a tick would otherwise fire shows that the residue is cleared. A counter preload near the top shows the wrap, and a write to an unused offset shows that it is ignored.

// File: rtl/usec_pkg.sv
package usec_pkg;

    localparam int FIELD_W = 8;
    localparam int CFG_W   = 2 * FIELD_W;
    localparam int ACC_W   = FIELD_W + 2;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 32;

    localparam logic [7:0] OFS_COUNT = 8'h10;
    localparam logic [7:0] OFS_RATIO = 8'h14;

    // S field in the upper byte, M field in the lower byte
    typedef struct packed {
        logic [FIELD_W-1:0] share_m1;
        logic [FIELD_W-1:0] cycles_m1;
    } ratio_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_RATIO
    } reg_sel_e;

    function automatic logic [ACC_W-1:0] modulus_of(ratio_t r);
        return ACC_W'(r.cycles_m1) + ACC_W'(1);
    endfunction

    // step added per clock, clamped so that the ratio never exceeds one tick per clock
    function automatic logic [ACC_W-1:0] step_of(ratio_t r);
        logic [ACC_W-1:0] s;
        s = ACC_W'(r.share_m1) + ACC_W'(1);
        if (r.share_m1 > r.cycles_m1)
            s = modulus_of(r);
        return s;
    endfunction

endpackage

// File: rtl/usec_regs.sv
module usec_regs
    import usec_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [15:0] RST_CFG = 16'h000B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output ratio_t            ratio,
    output logic              ratio_wr,
    output logic              count_ld,
    output logic [DATA_W-1:0] rdata
);

    reg_sel_e sel;
    ratio_t   ratio_q;

    always_comb begin
        if (addr == ADDR_W'(OFS_RATIO))
            sel = SEL_RATIO;
        else if (addr == ADDR_W'(OFS_COUNT))
            sel = SEL_COUNT;
        else
            sel = SEL_NONE;
    end

    assign ratio_wr = wr && (sel == SEL_RATIO);
    assign count_ld = wr && (sel == SEL_COUNT);

    always_ff @(posedge clk) begin
        if (rst)
            ratio_q <= ratio_t'(RST_CFG);
        else if (ratio_wr)
            ratio_q <= ratio_t'(wdata[CFG_W-1:0]);
    end

    assign ratio = ratio_q;

    always_comb begin
        unique case (sel)
            SEL_RATIO: rdata = DATA_W'(ratio_q);
            SEL_COUNT: rdata = DATA_W'(count);
            default:   rdata = '0;
        endcase
    end

    AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ratio_wr |=> $stable(ratio_q)); // R9

endmodule

// File: rtl/usec_accum.sv
module usec_accum
    import usec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  ratio_t ratio,
    output logic   hit,
    output logic   tick_q
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] modulus;

    assign modulus = modulus_of(ratio);
    assign sum     = acc_q + step_of(ratio);
    assign hit     = !clr && (sum >= modulus);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= hit ? (sum - modulus) : sum;
            tick_q <= hit;
        end
    end

    AST_RESIDUE_BELOW_MOD: assert property (@(posedge clk) disable iff (rst)
        acc_q < modulus); // R3
    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!tick_q && acc_q == '0)); // R5

endmodule

// File: rtl/usec_counter.sv
module usec_counter
    import usec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (ld)
            count <= ld_val;
        else if (inc)
            count <= count + CNT_W'(1);
    end

endmodule

// File: rtl/usec_prescaler.sv
module usec_prescaler
    import usec_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [15:0] RST_CFG = 16'h000B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tick_o
);

    ratio_t           ratio;
    logic             ratio_wr;
    logic             count_ld;
    logic             hit;
    logic [CNT_W-1:0] count;

    usec_regs #(.ADDR_W(ADDR_W), .RST_CFG(RST_CFG)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .count    (count),
        .ratio    (ratio),
        .ratio_wr (ratio_wr),
        .count_ld (count_ld),
        .rdata    (reg_rdata)
    );

    usec_accum accum_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (ratio_wr),
        .ratio  (ratio),
        .hit    (hit),
        .tick_q (tick_o)
    );

    usec_counter counter_i (
        .clk    (clk),
        .rst    (rst),
        .ld     (count_ld),
        .ld_val (reg_wdata[CNT_W-1:0]),
        .inc    (hit),
        .count  (count)
    );

    AST_COUNT_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (rst)
        !count_ld |=> (count - $past(count)) == CNT_W'(tick_o)); // R6
    AST_WRITE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        ratio_wr |=> (count == $past(count))); // R5

endmodule

// File: tb/usec_prescaler_tb.sv
module usec_prescaler_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [7:0] A_CNT = 8'h10;
    localparam logic [7:0] A_CFG = 8'h14;

    always #5 clk = ~clk;

    usec_prescaler dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tick_o    (tick_o)
    );

    function automatic longint exp_ticks(logic [15:0] cfg, longint n);
        longint a, b;
        a = longint'(cfg[15:8]) + 1;
        b = longint'(cfg[7:0]) + 1;
        if (a > b) a = b;
        return (n * a) / b;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // Called just after a negedge; the write lands on the next posedge.
    task automatic wr_ratio_run(logic [31:0] cfg, int n, string tag);
        logic [31:0] c0, c1;
        rd(A_CNT, c0);
        reg_wr = 1'b1; reg_addr = A_CFG; reg_wdata = cfg;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (n) @(negedge clk);
        rd(A_CNT, c1);
        check(tag, c1 - c0, 32'(exp_ticks(cfg[15:0], n)));
    endtask

    task automatic wr_reg(logic [7:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c0;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CFG, v); check("R1 ratio reset", v, 32'h0000000B);
        rd(A_CNT, v); check("R1 counter reset", v, 32'h0);
        check("R1 tick reset", 32'(tick_o), 32'h0);

        // R2 field layout and upper bits ignored
        wr_reg(A_CFG, 32'hABCD_045F);
        rd(A_CFG, v); check("R2 readback", v, 32'h0000045F);

        // R4 integer spacing at 12 MHz
        wr_reg(A_CFG, 32'h0000000B);
        repeat (10) @(negedge clk);
        check("R4 tick low before 12th", 32'(tick_o), 32'h0);
        @(negedge clk);
        check("R4 tick low at 11th", 32'(tick_o), 32'h0);
        @(negedge clk);
        check("R4 tick high at 12th", 32'(tick_o), 32'h1);
        @(negedge clk);
        check("R4 tick low at 13th", 32'(tick_o), 32'h0);

        // R3 directed ratios
        wr_ratio_run(32'h0000000B, 1200, "R3 12MHz");
        wr_ratio_run(32'h0000000C, 1300, "R3 13MHz");
        wr_ratio_run(32'h0000043F, 1280, "R3 12.8MHz");
        wr_ratio_run(32'h0000045F, 1925, "R3 19.2MHz");
        wr_ratio_run(32'h000004BF, 3850, "R3 38.4MHz");
        wr_ratio_run(32'h00000019, 2600, "R3 26MHz");
        wr_ratio_run(32'h0000002F, 997,  "R3 48MHz");

        // R8 clamp
        wr_ratio_run(32'h00000503, 50, "R8 share above cycles");

        // R5 write clears residue and does not tick
        wr_reg(A_CFG, 32'h00000000);
        repeat (3) @(negedge clk);
        rd(A_CNT, c0);
        reg_wr = 1'b1; reg_addr = A_CFG; reg_wdata = 32'h00000007;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R5 no tick on write", 32'(tick_o), 32'h0);
        rd(A_CNT, v); check("R5 count held on write", v, c0);

        // R7 load and wrap at one tick per clock
        wr_reg(A_CFG, 32'h00000000);
        wr_reg(A_CNT, 32'hFFFF_FFF0);
        rd(A_CNT, v); check("R7 load", v, 32'hFFFF_FFF0);
        repeat (20) @(negedge clk);
        rd(A_CNT, v); check("R7 wrap", v, 32'h0000_0004);

        // R9 unmapped offsets
        wr_reg(A_CFG, 32'h0000045F);
        wr_reg(8'h18, 32'h0000_0000);
        rd(A_CFG, v); check("R9 ratio unchanged", v, 32'h0000045F);
        rd(8'h04, v); check("R9 unmapped read", v, 32'h0);
        wr_reg(A_CFG, 32'h00000000);
        rd(A_CNT, c0);
        wr_reg(8'h0C, 32'h1234_5678);
        rd(A_CNT, v); check("R9 counter unaffected", v, c0 + 32'd1);

        // R6 count rises with tick
        wr_reg(A_CFG, 32'h00000002);
        @(negedge clk); @(negedge clk);
        rd(A_CNT, c0);
        @(negedge clk);
        check("R6 tick on 3rd edge", 32'(tick_o), 32'h1);
        rd(A_CNT, v); check("R6 count with tick", v, c0 + 32'd1);

        // R3 random ratios
        for (int i = 0; i < 8; i++) begin
            logic [31:0] cfg;
            int n;
            cfg = {16'h0, 8'($urandom), 8'($urandom)};
            n = 200 + int'($urandom % 1500);
            wr_ratio_run(cfg, n, "R3 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule